// File: doc/BRIEF.md
# Incremental Fuzzy Duty-Reference Controller

This block closes the voltage loop of a switching converter with a sampled type-1 fuzzy rule base. On every accepted sample strobe it reads two signed fixed-point inputs: the normalised voltage error and the change of that error since the previous sample. Each input is fuzzified over five overlapping triangular labels. Four rules fire, each through a min of two grades, and a weighted average of their singleton consequents gives a crisp increment. The block adds that increment to a stored duty reference, which then feeds an external PWM comparator.

The weighted average runs on a shared bit-serial divider, so one update takes a fixed number of clock cycles. During that time a new strobe is not accepted. A one-cycle done pulse marks the moment the new reference is available. Scaling of the raw voltages and generation of the PWM carrier happen outside the block.

Top module: `fz_duty_ctrl`

## Requirements
- R1: After reset, `duty_ref_o` is 0 and `done_o` is low.
- R2: An input above +1.0 (16384 in Q1.14) is treated as +1.0, and an input below -1.0 is treated as -1.0.
- R3: Each input has five labels with index 0 to 4, peaking at -1, -0.5, 0, +0.5 and +1. For labels i (error) and j (change), the rule singleton is (i + j - 4) * 0.5 clamped to [-1, 1]. For example, error 0 with change +0.5 gives +0.5.
- R4: The firing strength of a rule is the minimum of its two triangular grades. The increment is the sum of strength times singleton, divided by the sum of strengths. The quotient magnitude is truncated toward zero, and the increment is zero when the strength sum is zero.
- R5: The new reference is the old reference plus the increment, saturated to [0, 16384].
- R6: `done_o` goes high for exactly one cycle, 2*FRAC+6 rising edges after the edge that accepts a strobe. `duty_ref_o` changes only in the cycle just before `done_o` rises.
- R7: A strobe that arrives while an update is in progress is ignored. It produces no extra done pulse and does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample strobe; accepted when idle |
| err_i | input | W | Signed Q1.14 voltage error |
| derr_i | input | W | Signed Q1.14 change of error |
| duty_ref_o | output | W | Signed Q1.14 accumulated duty reference, range [0, 1.0] |
| done_o | output | 1 | One-cycle pulse when a new reference is available |

## Verification
With default parameters the increment is ready 32 edges after the accepting edge, the reference register loads on edge 33, and the done pulse is visible after edge 34. The bench counts falling edges from the accepting edge until it sees done. It requires that count to equal 34, and only then compares the reference with the value from its own fuzzy model. It checks on the next falling edge that done has dropped. For the busy-strobe case, it watches two further update periods to confirm that no second pulse appears and that the reference holds.

// File: rtl/fz_pkg.sv
`timescale 1ns/1ps
package fz_pkg;

  typedef enum logic [2:0] {
    LBL_NEG_BIG   = 3'd0,
    LBL_NEG_SMALL = 3'd1,
    LBL_ZERO      = 3'd2,
    LBL_POS_SMALL = 3'd3,
    LBL_POS_BIG   = 3'd4
  } fz_label_e;

  // Rule consequent in half-steps: label sum minus 4, clamped to +/-2 (R3).
  function automatic logic signed [2:0] fz_step(input logic [2:0] lbl_e,
                                                input logic [2:0] lbl_d);
    logic signed [4:0] s;
    s = $signed({2'b00, lbl_e}) + $signed({2'b00, lbl_d}) - 5'sd4;
    if (s > 5'sd2) s = 5'sd2;
    else if (s < -5'sd2) s = -5'sd2;
    return s[2:0];
  endfunction

endpackage

// File: rtl/fz_fuzzify.sv
`timescale 1ns/1ps
module fz_fuzzify #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic signed [W-1:0] x_i,
  output logic [1:0]          seg_o,
  output logic [W-1:0]        g_lo_o,
  output logic [W-1:0]        g_hi_o
);
  localparam int XW    = W + 1;
  localparam int ONE_I = 1 << FRAC;

  logic signed [XW-1:0] xe, xs;
  logic [XW-1:0]        off, part;
  logic [2:0]           seg3;

  always_comb begin
    xe = {x_i[W-1], x_i};
    // Saturate into the universe [-1, 1] (R2)
    if (xe > XW'(ONE_I))       xs = XW'(ONE_I);
    else if (xe < -XW'(ONE_I)) xs = -XW'(ONE_I);
    else                       xs = xe;
    off  = $unsigned(xs + XW'(ONE_I));
    seg3 = off[FRAC+1:FRAC-1];
    if (seg3 > 3'd3) seg3 = 3'd3;
    part   = off - (XW'(seg3) << (FRAC-1));
    g_hi_o = W'(part << 1);
    g_lo_o = W'(ONE_I) - g_hi_o;
  end

  assign seg_o = seg3[1:0];
endmodule

// File: rtl/fz_rule_eval.sv
`timescale 1ns/1ps
module fz_rule_eval import fz_pkg::*; #(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int NUMW = 32,
  parameter int DENW = 17
) (
  input  logic [1:0]             seg_e_i,
  input  logic [1:0]             seg_d_i,
  input  logic [W-1:0]           ge_lo_i,
  input  logic [W-1:0]           ge_hi_i,
  input  logic [W-1:0]           gd_lo_i,
  input  logic [W-1:0]           gd_hi_i,
  output logic signed [NUMW-1:0] num_o,
  output logic [DENW-1:0]        den_o
);
  localparam int NRULE = 4;

  logic [W-1:0]           str  [NRULE];
  logic signed [NUMW-1:0] prod [NRULE];

  for (genvar a = 0; a < 2; a++) begin : g_err
    for (genvar b = 0; b < 2; b++) begin : g_der
      localparam int K = 2*a + b;
      logic [W-1:0]           ga, gb;
      logic signed [2:0]      step;
      logic signed [NUMW-1:0] wgt;
      assign ga   = (a == 0) ? ge_lo_i : ge_hi_i;
      assign gb   = (b == 0) ? gd_lo_i : gd_hi_i;
      assign step = fz_step({1'b0, seg_e_i} + 3'(a), {1'b0, seg_d_i} + 3'(b));
      assign wgt  = NUMW'(step) <<< (FRAC-1);
      assign str[K]  = (ga < gb) ? ga : gb;
      assign prod[K] = $signed({{(NUMW-W){1'b0}}, str[K]}) * wgt;
    end
  end

  always_comb begin
    num_o = '0;
    den_o = '0;
    for (int k = 0; k < NRULE; k++) begin
      num_o = num_o + prod[k];
      den_o = den_o + DENW'(str[k]);
    end
  end
endmodule

// File: rtl/fz_seq_div.sv
`timescale 1ns/1ps
module fz_seq_div #(
  parameter int NW = 32,
  parameter int DW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [NW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic [NW-1:0] quot_o,
  output logic          valid_o
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q, dsr_q;
  logic [NW-1:0] quo_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic [DW:0]   rem_sh, rem_sub;
  logic          fits;

  always_comb begin
    rem_sh  = {rem_q, quo_q[NW-1]};
    fits    = rem_sh >= {1'b0, dsr_q};
    rem_sub = fits ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      dsr_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (cnt_q == '0) begin
        if (start_i) begin
          rem_q <= '0;
          quo_q <= dividend_i;
          dsr_q <= divisor_i;
          cnt_q <= CW'(NW);
        end
      end else begin
        rem_q <= rem_sub[DW-1:0];
        quo_q <= {quo_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) valid_q <= 1'b1;
      end
    end
  end

  assign quot_o  = quo_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/fz_duty_ctrl.sv
`timescale 1ns/1ps
module fz_duty_ctrl #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sample_i,
  input  logic signed [W-1:0] err_i,
  input  logic signed [W-1:0] derr_i,
  output logic signed [W-1:0] duty_ref_o,
  output logic                done_o
);
  localparam int NUMW  = 2*FRAC + 4;
  localparam int DENW  = FRAC + 3;
  localparam int ONE_I = 1 << FRAC;

  logic signed [W-1:0] xin  [2];
  logic [1:0]          seg  [2];
  logic [W-1:0]        g_lo [2];
  logic [W-1:0]        g_hi [2];

  assign xin[0] = err_i;
  assign xin[1] = derr_i;

  for (genvar i = 0; i < 2; i++) begin : g_fz
    fz_fuzzify #(.W(W), .FRAC(FRAC)) u_fz (
      .x_i(xin[i]), .seg_o(seg[i]), .g_lo_o(g_lo[i]), .g_hi_o(g_hi[i])
    );
  end

  logic signed [NUMW-1:0] num;
  logic [DENW-1:0]        den;

  fz_rule_eval #(.W(W), .FRAC(FRAC), .NUMW(NUMW), .DENW(DENW)) u_rules (
    .seg_e_i(seg[0]), .seg_d_i(seg[1]),
    .ge_lo_i(g_lo[0]), .ge_hi_i(g_hi[0]),
    .gd_lo_i(g_lo[1]), .gd_hi_i(g_hi[1]),
    .num_o(num), .den_o(den)
  );

  logic            busy_q, neg_q, dz_q, done_pend_q, done_q;
  logic            accept, div_valid;
  logic [NUMW-1:0] num_abs, div_quot;
  logic signed [W-1:0]    duty_q, duty_next;
  logic signed [NUMW-1:0] inc, acc_sum;

  assign accept  = sample_i && !busy_q;
  assign num_abs = num[NUMW-1] ? $unsigned(-num) : $unsigned(num);

  fz_seq_div #(.NW(NUMW), .DW(DENW)) u_div (
    .clk(clk), .rst(rst), .start_i(accept),
    .dividend_i(num_abs), .divisor_i(den),
    .quot_o(div_quot), .valid_o(div_valid)
  );

  always_comb begin
    if (dz_q)       inc = '0;
    else if (neg_q) inc = -$signed(div_quot);
    else            inc = $signed(div_quot);
    acc_sum = NUMW'(duty_q) + inc;
    if (acc_sum < 0)                     duty_next = '0;
    else if (acc_sum > NUMW'(ONE_I))     duty_next = W'(ONE_I);
    else                                 duty_next = acc_sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      neg_q       <= 1'b0;
      dz_q        <= 1'b0;
      done_pend_q <= 1'b0;
      done_q      <= 1'b0;
      duty_q      <= '0;
    end else begin
      done_q      <= done_pend_q;
      done_pend_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        neg_q  <= num[NUMW-1];
        dz_q   <= (den == '0);
      end
      if (div_valid) begin
        duty_q      <= duty_next;
        done_pend_q <= 1'b1;
      end
      if (done_pend_q) busy_q <= 1'b0;
    end
  end

  assign duty_ref_o = duty_q;
  assign done_o     = done_q;
endmodule

// File: rtl/fz_duty_ctrl_chk.sv
`timescale 1ns/1ps
module fz_duty_ctrl_chk #(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int NUMW = 32
) (
  input logic                clk,
  input logic                rst,
  input logic signed [W-1:0] duty_ref,
  input logic                done,
  input logic                div_valid,
  input logic [NUMW-1:0]     quot
);
  localparam int ONE_I = 1 << FRAC;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (duty_ref == '0 && !done));

  assert_inc_bound_R4: assert property (@(posedge clk) disable iff (rst)
    div_valid |-> (quot <= NUMW'(ONE_I)));

  assert_ref_range_R5: assert property (@(posedge clk) disable iff (rst)
    (duty_ref >= 0 && duty_ref <= W'(ONE_I)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_ref_then_done_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_ref) |=> done);
endmodule

bind fz_duty_ctrl fz_duty_ctrl_chk #(.W(W), .FRAC(FRAC), .NUMW(NUMW)) u_chk (
  .clk(clk), .rst(rst), .duty_ref(duty_ref_o), .done(done_o),
  .div_valid(div_valid), .quot(div_quot)
);

// File: tb/fz_duty_ctrl_bench.sv
`timescale 1ns/1ps
module fz_duty_ctrl_bench;
  localparam int W     = 16;
  localparam int FRAC  = 14;
  localparam int ONE   = 1 << FRAC;
  localparam int HALF  = 1 << (FRAC-1);
  localparam int LAT   = 2*FRAC + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample = 1'b0;
  logic signed [W-1:0] err = '0, derr = '0;
  logic signed [W-1:0] duty;
  logic done;

  int checks = 0;
  int errors = 0;
  int model  = 0;

  always #10 clk = ~clk;

  fz_duty_ctrl #(.W(W), .FRAC(FRAC)) u_fz_duty_ctrl (
    .clk(clk), .rst(rst), .sample_i(sample), .err_i(err), .derr_i(derr),
    .duty_ref_o(duty), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void fuzz(input int x, output int seg, output int glo, output int ghi);
    int off, f;
    if (x > ONE) x = ONE;
    if (x < -ONE) x = -ONE;
    off = x + ONE;
    seg = off / HALF;
    if (seg > 3) seg = 3;
    f   = off - seg*HALF;
    ghi = 2*f;
    glo = ONE - ghi;
  endfunction

  function automatic int ref_inc(input int e, input int d);
    int se, sd, gel, geh, gdl, gdh;
    longint num, den, q;
    num = 0; den = 0;
    fuzz(e, se, gel, geh);
    fuzz(d, sd, gdl, gdh);
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        int ga, gb, s, st;
        ga = (a == 0) ? gel : geh;
        gb = (b == 0) ? gdl : gdh;
        s  = (ga < gb) ? ga : gb;
        st = se + a + sd + b - 4;
        if (st > 2) st = 2;
        if (st < -2) st = -2;
        num += longint'(s) * st * HALF;
        den += s;
      end
    end
    if (den == 0) return 0;
    q = ((num < 0) ? -num : num) / den;
    return int'((num < 0) ? -q : q);
  endfunction

  // One update; optional busy-time strobe for R7
  task automatic run(input int e, input int d, input string tag, input bit inject);
    int exp_ref, cnt;
    exp_ref = model + ref_inc(e, d);
    if (exp_ref < 0) exp_ref = 0;
    if (exp_ref > ONE) exp_ref = ONE;
    @(negedge clk);
    err = W'(e); derr = W'(d); sample = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sample = 1'b0;
    cnt = 0;
    while (!done && cnt < LAT + 20) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 5) begin
        err = W'(-e); derr = W'(-d); sample = 1'b1;
      end else begin
        sample = 1'b0;
      end
    end
    check(cnt == LAT, "R6 done latency", cnt, LAT);
    check(duty == W'(exp_ref), tag, int'(duty), exp_ref);
    model = exp_ref;
    @(negedge clk);
    check(!done, "R6 single-cycle done", int'(done), 0);
    if (inject) begin
      bit seen;
      seen = 1'b0;
      for (int k = 0; k < 2*LAT; k++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      check(!seen, "R7 no extra done", int'(seen), 0);
      check(duty == W'(exp_ref), "R7 reference held", int'(duty), exp_ref);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R6 watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(duty == '0, "R1 reset reference", int'(duty), 0);
    check(!done, "R1 reset done", int'(done), 0);

    run(0, HALF, "R3 Z with PS gives +0.5", 1'b0);
    run(-ONE, -ONE, "R5 lower clamp at 0", 1'b0);
    run(ONE, ONE, "R3 PB with PB gives +1", 1'b0);
    run(HALF, HALF, "R5 upper clamp at 1.0", 1'b0);
    run(-HALF, 0, "R3 NS with Z gives -0.5", 1'b0);
    run(-32768, HALF, "R2 saturated negative error", 1'b0);
    run(32767, 32767, "R2 saturated positive inputs", 1'b0);
    run(HALF/2, -HALF/2, "R4 balanced midpoint", 1'b0);
    run(HALF/2, 3*HALF/4, "R7 busy strobe ignored", 1'b1);

    for (int n = 0; n < 40; n++) begin
      int e, d;
      if (n % 4 == 0) begin
        e = int'($signed(16'($urandom())));
        d = int'($signed(16'($urandom())));
      end else begin
        e = int'($urandom_range(2*ONE)) - ONE;
        d = int'($urandom_range(2*ONE)) - ONE;
      end
      run(e, d, "R4 random weighted average", 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule